// File: doc/BRIEF.md
# Memory Access Stage Controller

This block is the memory stage of an in-order integer pipeline. The execute stage hands it one load or store per cycle through a valid flag and a small instruction record. The stage keeps that instruction in a one-entry holding slot. It then finishes the cache handshake. A store drives its address, data and a write request toward the cache. It repeats that request on every cycle until the cache answers with a grant. A load sends nothing, because its address was issued upstream. It waits until the memory side strobes returned data.

When load data arrives, the value is written into the rename copy of the destination register in that same cycle. The instruction is also registered into the writeback latch, so writeback sees it on the next cycle. A store never reaches writeback. While the access is still open, the stage drives a combinational stall back to execute. It keeps its held instruction and ignores its input until the access completes. Only one access is outstanding at a time. On the edge where an access completes, the next instruction can be taken in, so no bubble is inserted.

Top module: `memstage_ctrl`

## Requirements
- R1: During and right after reset the stage is empty: `hold_stall`, `wr_req`, `ren_we` and `wb_valid` are all 0.
- R2: While a store (`op_store`=1) is held, `wr_req` is 1 in every cycle, with `wr_addr`/`wr_data` equal to the accepted address and data, until a cycle in which `wr_gnt` is 1.
- R3: A held load (`op_store`=0) never drives `wr_req`; it completes only in a cycle with `rd_valid`=1.
- R4: `hold_stall` is 1 in exactly those cycles in which an instruction is held and its completion strobe (`wr_gnt` for a store, `rd_valid` for a load) is absent in that same cycle; it responds combinationally.
- R5: While `hold_stall` is 1, a new instruction offered on the input is ignored and the held address and data stay unchanged.
- R6: In the cycle a held load sees `rd_valid`=1, `ren_we`=1 with `ren_idx` equal to the load's destination and `ren_data` equal to `rd_data`.
- R7: A load that completes at a clock edge makes `wb_valid`=1 for the following cycle, with `wb_dst`/`wb_data` equal to that load's destination and data; a completed store leaves `wb_valid` at 0.
- R8: Strobes that do not apply are ignored: with no instruction held, `wr_gnt` and `rd_valid` cause no `ren_we`, no `wb_valid` and no stall; a held store ignores `rd_valid`.
- R9: On the same edge at which an access completes, a valid input instruction is accepted, so it is serviced in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Execute stage offers an instruction |
| in_store | input | 1 | 1 = store, 0 = load |
| in_addr | input | AW | Memory address of the access |
| in_wdata | input | DW | Store data |
| in_dst | input | log2(NREGS) | Load destination register index |
| hold_stall | output | 1 | Stall toward execute (combinational) |
| wr_req | output | 1 | Store write request to cache |
| wr_addr | output | AW | Store address |
| wr_data | output | DW | Store data |
| wr_gnt | input | 1 | Cache grants the store |
| rd_valid | input | 1 | Memory returns load data |
| rd_data | input | DW | Returned load data |
| ren_we | output | 1 | Rename register write enable |
| ren_idx | output | log2(NREGS) | Rename register index |
| ren_data | output | DW | Rename register write value |
| wb_valid | output | 1 | Writeback latch holds a finished load |
| wb_dst | output | log2(NREGS) | Writeback destination index |
| wb_data | output | DW | Writeback value |

## Verification
An instruction offered in one cycle is held from the next clock edge on. `hold_stall`, `wr_req` and `ren_we` then show up combinationally in that next cycle, in response to the strobes present in it. `wb_valid` appears one edge after the cycle in which the load's data arrived. The bench changes inputs on the falling edge and samples every output one nanosecond later, before the next rising edge. Each table row therefore lists the combinational results of the current strobes next to the registered results of the previous row, and those expectations are worked out by hand from the requirements.

// File: rtl/memstage_pkg.sv
package memstage_pkg;

  typedef enum logic {
    OP_LOAD  = 1'b0,
    OP_STORE = 1'b1
  } mem_op_e;

endpackage

// File: rtl/ms_slot.sv
module ms_slot
  import memstage_pkg::*;
#(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              take_en,
  input  logic              in_valid,
  input  logic              in_store,
  input  logic [AW-1:0]     in_addr,
  input  logic [DW-1:0]     in_wdata,
  input  logic [RIDX_W-1:0] in_dst,
  output logic              occ,
  output mem_op_e           op,
  output logic [AW-1:0]     addr,
  output logic [DW-1:0]     wdata,
  output logic [RIDX_W-1:0] dst
);

  logic occ_n;
  logic fld_en;

  always_comb begin
    occ_n  = occ;
    fld_en = 1'b0;
    if (take_en) begin
      occ_n  = in_valid;
      fld_en = in_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ <= 1'b0;
    end else begin
      occ <= occ_n;
    end
  end

  always_ff @(posedge clk) begin
    if (fld_en) begin
      op    <= in_store ? OP_STORE : OP_LOAD;
      addr  <= in_addr;
      wdata <= in_wdata;
      dst   <= in_dst;
    end
  end

endmodule

// File: rtl/ms_resolve.sv
module ms_resolve
  import memstage_pkg::*;
(
  input  logic    occ,
  input  mem_op_e op,
  input  logic    wr_gnt,
  input  logic    rd_valid,
  output logic    wr_req,
  output logic    load_done,
  output logic    stall
);

  logic store_done;

  always_comb begin
    wr_req     = occ && (op == OP_STORE);
    store_done = wr_req && wr_gnt;
    load_done  = occ && (op == OP_LOAD) && rd_valid;
    stall      = occ && !(store_done || load_done);
  end

endmodule

// File: rtl/ms_wbreg.sv
module ms_wbreg #(
  parameter int DW     = 32,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_done,
  input  logic [RIDX_W-1:0] done_dst,
  input  logic [DW-1:0]     done_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_dst,
  output logic [DW-1:0]     wb_data
);

  logic valid_n;

  always_comb begin
    valid_n = load_done;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_valid <= 1'b0;
    end else begin
      wb_valid <= valid_n;
    end
  end

  always_ff @(posedge clk) begin
    if (load_done) begin
      wb_dst  <= done_dst;
      wb_data <= done_data;
    end
  end

endmodule

// File: rtl/memstage_ctrl.sv
module memstage_ctrl
  import memstage_pkg::*;
#(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int NREGS = 32,
  localparam int RIDX_W = $clog2(NREGS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic              in_store,
  input  logic [AW-1:0]     in_addr,
  input  logic [DW-1:0]     in_wdata,
  input  logic [RIDX_W-1:0] in_dst,
  output logic              hold_stall,
  output logic              wr_req,
  output logic [AW-1:0]     wr_addr,
  output logic [DW-1:0]     wr_data,
  input  logic              wr_gnt,
  input  logic              rd_valid,
  input  logic [DW-1:0]     rd_data,
  output logic              ren_we,
  output logic [RIDX_W-1:0] ren_idx,
  output logic [DW-1:0]     ren_data,
  output logic              wb_valid,
  output logic [RIDX_W-1:0] wb_dst,
  output logic [DW-1:0]     wb_data
);

  logic              slot_occ;
  mem_op_e           slot_op;
  logic [RIDX_W-1:0] slot_dst;
  logic              load_done;

  ms_slot #(.AW(AW), .DW(DW), .RIDX_W(RIDX_W)) u_slot (
    .clk      (clk),
    .rst_n    (rst_n),
    .take_en  (!hold_stall),
    .in_valid (in_valid),
    .in_store (in_store),
    .in_addr  (in_addr),
    .in_wdata (in_wdata),
    .in_dst   (in_dst),
    .occ      (slot_occ),
    .op       (slot_op),
    .addr     (wr_addr),
    .wdata    (wr_data),
    .dst      (slot_dst)
  );

  ms_resolve u_resolve (
    .occ       (slot_occ),
    .op        (slot_op),
    .wr_gnt    (wr_gnt),
    .rd_valid  (rd_valid),
    .wr_req    (wr_req),
    .load_done (load_done),
    .stall     (hold_stall)
  );

  always_comb begin
    ren_we   = load_done;
    ren_idx  = slot_dst;
    ren_data = rd_data;
  end

  ms_wbreg #(.DW(DW), .RIDX_W(RIDX_W)) u_wb (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_done (load_done),
    .done_dst  (slot_dst),
    .done_data (rd_data),
    .wb_valid  (wb_valid),
    .wb_dst    (wb_dst),
    .wb_data   (wb_data)
  );

endmodule

// File: rtl/memstage_ctrl_chk.sv
module memstage_ctrl_chk #(
  parameter int AW     = 32,
  parameter int DW     = 32,
  parameter int RIDX_W = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              slot_occ,
  input logic              hold_stall,
  input logic              wr_req,
  input logic [AW-1:0]     wr_addr,
  input logic [DW-1:0]     wr_data,
  input logic              wr_gnt,
  input logic              ren_we,
  input logic [RIDX_W-1:0] ren_idx,
  input logic [DW-1:0]     ren_data,
  input logic              wb_valid,
  input logic [RIDX_W-1:0] wb_dst,
  input logic [DW-1:0]     wb_data
);

  assert_store_retry_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !wr_gnt) |=> (wr_req && $stable(wr_addr) && $stable(wr_data)));

  assert_load_no_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ren_we |-> !wr_req);

  assert_stall_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    hold_stall |=> (slot_occ && $stable(wr_addr) && $stable(wr_data)));

  assert_wb_follows_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ren_we |=> (wb_valid && wb_dst == $past(ren_idx) && wb_data == $past(ren_data)));

  assert_store_no_wb_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && wr_gnt) |=> !wb_valid);

  assert_empty_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_occ |-> (!ren_we && !wr_req && !hold_stall));

endmodule

bind memstage_ctrl memstage_ctrl_chk #(.AW(AW), .DW(DW), .RIDX_W(RIDX_W)) i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .slot_occ   (slot_occ),
  .hold_stall (hold_stall),
  .wr_req     (wr_req),
  .wr_addr    (wr_addr),
  .wr_data    (wr_data),
  .wr_gnt     (wr_gnt),
  .ren_we     (ren_we),
  .ren_idx    (ren_idx),
  .ren_data   (ren_data),
  .wb_valid   (wb_valid),
  .wb_dst     (wb_dst),
  .wb_data    (wb_data)
);

// File: tb/test_memstage_ctrl.sv
module test_memstage_ctrl;

  localparam int AW = 32;
  localparam int DW = 32;
  localparam int NR = 32;
  localparam int RW = $clog2(NR);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_store = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [DW-1:0] in_wdata = '0;
  logic [RW-1:0] in_dst = '0;
  logic          wr_gnt = 1'b0, rd_valid = 1'b0;
  logic [DW-1:0] rd_data = '0;
  logic          hold_stall, wr_req, ren_we, wb_valid;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] wr_data, ren_data, wb_data;
  logic [RW-1:0] ren_idx, wb_dst;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  memstage_ctrl #(.AW(AW), .DW(DW), .NREGS(NR)) i_memstage_ctrl (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_store(in_store),
    .in_addr(in_addr), .in_wdata(in_wdata), .in_dst(in_dst),
    .hold_stall(hold_stall), .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data),
    .wr_gnt(wr_gnt), .rd_valid(rd_valid), .rd_data(rd_data),
    .ren_we(ren_we), .ren_idx(ren_idx), .ren_data(ren_data),
    .wb_valid(wb_valid), .wb_dst(wb_dst), .wb_data(wb_data)
  );

  typedef struct packed {
    logic       iv;
    logic       st;
    logic [7:0] addr;
    logic [7:0] wd;
    logic [4:0] dst;
    logic       gnt;
    logic       dv;
    logic [7:0] ld;
    logic       e_stall;
    logic       e_req;
    logic [7:0] e_sd;
    logic       e_rnwe;
    logic [4:0] e_rni;
    logic [7:0] e_rnd;
    logic       e_wbv;
    logic [4:0] e_wbi;
    logic [7:0] e_wbd;
  } vec_t;

  localparam int NV = 10;
  // Per row: inputs for the cycle, then the outputs expected 1 ns later.
  localparam vec_t VECS [NV] = '{
    '{1,1,8'h10,8'hAA,5'd0, 0,0,8'h00, 0,0,8'h00, 0,5'd0,8'h00, 0,5'd0,8'h00}, // empty, store offered
    '{1,0,8'h20,8'h00,5'd3, 0,0,8'h00, 1,1,8'hAA, 0,5'd0,8'h00, 0,5'd0,8'h00}, // R5 load offered while store waits
    '{1,0,8'h20,8'h00,5'd3, 0,0,8'h00, 1,1,8'hAA, 0,5'd0,8'h00, 0,5'd0,8'h00}, // R2 retry
    '{1,0,8'h20,8'h00,5'd3, 1,0,8'h00, 0,1,8'hAA, 0,5'd0,8'h00, 0,5'd0,8'h00}, // grant, R9 load taken
    '{0,0,8'h00,8'h00,5'd0, 1,0,8'h00, 1,0,8'h00, 0,5'd0,8'h00, 0,5'd0,8'h00}, // R3 load ignores grant
    '{1,1,8'h30,8'h55,5'd7, 0,1,8'h5C, 0,0,8'h00, 1,5'd3,8'h5C, 0,5'd0,8'h00}, // R6 data arrives
    '{1,0,8'h40,8'h00,5'd9, 1,1,8'h11, 0,1,8'h55, 0,5'd0,8'h00, 1,5'd3,8'h5C}, // R7 wb, R8 store ignores rd_valid
    '{0,0,8'h00,8'h00,5'd0, 0,1,8'h77, 0,0,8'h00, 1,5'd9,8'h77, 0,5'd0,8'h00}, // R7 store gave no wb
    '{0,0,8'h00,8'h00,5'd0, 1,1,8'h66, 0,0,8'h00, 0,5'd0,8'h00, 1,5'd9,8'h77}, // R8 empty ignores strobes
    '{0,0,8'h00,8'h00,5'd0, 0,0,8'h00, 0,0,8'h00, 0,5'd0,8'h00, 0,5'd0,8'h00}  // drained
  };

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic drive(input vec_t v);
    in_valid = v.iv;
    in_store = v.st;
    in_addr  = {24'h0, v.addr};
    in_wdata = {24'h0, v.wd};
    in_dst   = v.dst;
    wr_gnt   = v.gnt;
    rd_valid = v.dv;
    rd_data  = {24'h0, v.ld};
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (2) @(negedge clk);
    #1;
    chk("R1", "stall in reset", {31'b0, hold_stall}, 0);
    chk("R1", "wb_valid in reset", {31'b0, wb_valid}, 0);
    rst_n = 1'b1;
    @(negedge clk); #1;
    chk("R1", "wr_req after reset", {31'b0, wr_req}, 0);
    chk("R1", "ren_we after reset", {31'b0, ren_we}, 0);

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VECS[i]);
      #1;
      chk("R4", $sformatf("row%0d stall", i), {31'b0, hold_stall}, {31'b0, VECS[i].e_stall});
      chk("R2", $sformatf("row%0d wr_req", i), {31'b0, wr_req}, {31'b0, VECS[i].e_req});
      if (VECS[i].e_req) begin
        chk("R5", $sformatf("row%0d wr_data", i), wr_data, {24'h0, VECS[i].e_sd});
      end
      chk("R6", $sformatf("row%0d ren_we", i), {31'b0, ren_we}, {31'b0, VECS[i].e_rnwe});
      if (VECS[i].e_rnwe) begin
        chk("R6", $sformatf("row%0d ren_idx", i), {27'b0, ren_idx}, {27'b0, VECS[i].e_rni});
        chk("R6", $sformatf("row%0d ren_data", i), ren_data, {24'h0, VECS[i].e_rnd});
      end
      chk("R7", $sformatf("row%0d wb_valid", i), {31'b0, wb_valid}, {31'b0, VECS[i].e_wbv});
      if (VECS[i].e_wbv) begin
        chk("R7", $sformatf("row%0d wb_dst", i), {27'b0, wb_dst}, {27'b0, VECS[i].e_wbi});
        chk("R7", $sformatf("row%0d wb_data", i), wb_data, {24'h0, VECS[i].e_wbd});
      end
    end

    // R2: store address held across retries
    @(negedge clk);
    in_valid = 1'b1; in_store = 1'b1; in_addr = 32'hCAFE0010; in_wdata = 32'h12345678;
    wr_gnt = 1'b0; rd_valid = 1'b0;
    @(negedge clk);
    in_addr = 32'h0BAD0000; in_wdata = 32'h0;
    #1;
    chk("R2", "retry addr", wr_addr, 32'hCAFE0010);
    @(negedge clk); #1;
    chk("R5", "held addr after ignored input", wr_addr, 32'hCAFE0010);
    chk("R2", "still requesting", {31'b0, wr_req}, 1);

    // R1: reset in the middle of a stall empties the stage
    rst_n = 1'b0;
    #1;
    chk("R1", "stall cleared by reset", {31'b0, hold_stall}, 0);
    chk("R1", "wr_req cleared by reset", {31'b0, wr_req}, 0);
    in_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_valid = 1'b1; rd_data = 32'hDEAD;
    #1;
    chk("R8", "rd_valid with empty stage", {31'b0, ren_we}, 0);
    @(negedge clk); #1;
    chk("R8", "no wb from stray data", {31'b0, wb_valid}, 0);
    rd_valid = 1'b0;

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule